// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block guards the memory regions reserved for system-management mode. It holds two control registers and an extended segment-size register, and decides for each access whether it reaches DRAM, is forwarded to the PCI/legacy bus, is absorbed by a dummy sink, or is left to the normal memory map. The decision depends on the address, on whether the requester is in system-management mode, and on the register state. Three regions are covered: the 128 KB legacy window at 0xA0000 to 0xBFFFF, a high alias of the same DRAM bytes at 0xFEDA0000 to 0xFEDBFFFF, and a segment of configurable size directly below the top of low memory (TSEG).

Software programs the registers through a plain write port and reads them back on plain outputs. Setting the lock bit closes the open bit and freezes both control registers until reset. Accesses enter on a valid/ready stream and leave, one cycle later, as a registered decision on a second valid/ready stream. An access is taken on a clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` is high whenever the output holds no decision or the consumer takes it in the same cycle, so the block buffers one decision and passes back-pressure straight upstream. A decision that is not taken stays on the outputs unchanged.

Top module: `smram_guard`

## Requirements
- R1: After reset the control register reads 0x00, the extended control register reads 0x00, the size register reads 0xFFFF (the query value) and `rsp_valid` is low.
- R2: While unlocked, a write with `wr_sel`=0 stores bit0 (global enable), bit1 (open) and bit2 (lock) of the control register. A write with `wr_sel`=1 stores bit0 (TSEG enable), bits 2:1 (size code) and bit3 (high enable) of the extended control register. Bits that are not used read as zero.
- R3: The lock bit can only be set. A write that sets it also leaves open at zero. After that, writes to both control registers change nothing until reset.
- R4: A normal access in the legacy window routes to DRAM when open=1 and high enable=0, and routes to the bus otherwise.
- R5: A normal access in the high alias routes to DRAM when open=1 and high enable=1, and is not claimed otherwise.
- R6: An SMM access routes to DRAM in the legacy window when global=1 and high enable=0, and in the high alias when global=1 and high enable=1. Otherwise it gets the normal result.
- R7: With TSEG enabled, size code 0, 1, 2 or 3 selects 1, 2 or 8 MB or EXT_MB MB. The segment covers [tolm − size, tolm). With TSEG disabled the segment is empty.
- R8: A non-SMM access in TSEG routes to the sink. A read returns `rsp_rdata`=0xFFFFFFFF, and a write returns 0 and is discarded.
- R9: An SMM access in TSEG routes to DRAM.
- R10: Writing the query value 0xFFFF to the size register (`wr_sel`=2) loads EXT_MB. Any other value is stored as written.
- R11: A decision that is not taken keeps `rsp_valid` high and its fields unchanged, and `acc_ready` stays low during that time.
- R12: Addresses outside all three regions are not claimed. Route codes are 0 (not claimed), 1 (DRAM), 2 (bus) and 3 (sink).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 extended control, 2 size |
| wr_data | input | 16 | Write data |
| ctrl_rd | output | 8 | Control register readback |
| ectrl_rd | output | 8 | Extended control readback |
| xsize_rd | output | 16 | Size register readback |
| tolm | input | 32 | Top of low memory |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Access accepted |
| acc_addr | input | 32 | Access address |
| acc_smm | input | 1 | Requester in system-management mode |
| acc_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Decision available |
| rsp_ready | input | 1 | Decision taken |
| rsp_route | output | 2 | Route code |
| rsp_rdata | output | 32 | Sink read data |

## Verification
The assertions assume that `tolm` holds steady while accesses are in flight and that the consumer never drops a pending decision other than through `rsp_ready`. The stimulus changes `tolm` and the register state only while no decision is pending. The bench checks the stall rule with `rsp_ready` held low across more than one cycle, and checks the lock rule last, followed by a fresh reset.

// File: rtl/smg_pkg.sv
package smg_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int REG_W  = 16;

  typedef enum logic [1:0] {
    RT_PASS = 2'd0,
    RT_DRAM = 2'd1,
    RT_BUS  = 2'd2,
    RT_SINK = 2'd3
  } route_e;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ECTRL = 2'd1;
  localparam logic [1:0] SEL_XSIZE = 2'd2;

  localparam logic [ADDR_W-1:0] LOW_LO  = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] LOW_HI  = 32'h000B_FFFF;
  localparam logic [ADDR_W-1:0] HIGH_LO = 32'hFEDA_0000;
  localparam logic [ADDR_W-1:0] HIGH_HI = 32'hFEDB_FFFF;
  localparam logic [REG_W-1:0]  QUERY   = 16'hFFFF;
endpackage

// File: rtl/smg_regs.sv
module smg_regs
  import smg_pkg::*;
#(
  parameter int EXT_MB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             g_en,
  output logic             open_q,
  output logic             lock_q,
  output logic             t_en,
  output logic [1:0]       t_code,
  output logic             h_en,
  output logic [7:0]       ctrl_rd,
  output logic [7:0]       ectrl_rd,
  output logic [REG_W-1:0] xsize_rd
);
  localparam logic [REG_W-1:0] XS_RESET = (EXT_MB > 0) ? QUERY : '0;
  localparam logic [REG_W-1:0] XS_CFG   = REG_W'(EXT_MB);

  logic [REG_W-1:0] xsize_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_en    <= 1'b0;
      open_q  <= 1'b0;
      lock_q  <= 1'b0;
      t_en    <= 1'b0;
      t_code  <= 2'd0;
      h_en    <= 1'b0;
      xsize_q <= XS_RESET;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: if (!lock_q) begin
          g_en   <= wr_data[0];
          lock_q <= wr_data[2];
          open_q <= wr_data[1] & ~wr_data[2];
        end
        SEL_ECTRL: if (!lock_q) begin
          t_en   <= wr_data[0];
          t_code <= wr_data[2:1];
          h_en   <= wr_data[3];
        end
        SEL_XSIZE: xsize_q <= (wr_data == QUERY && EXT_MB > 0) ? XS_CFG : wr_data;
        default: ;
      endcase
    end
  end

  assign ctrl_rd  = {5'd0, lock_q, open_q, g_en};
  assign ectrl_rd = {4'd0, h_en, t_code, t_en};
  assign xsize_rd = xsize_q;

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R3
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && wr_sel != SEL_XSIZE) |=> ($stable(ctrl_rd) && $stable(ectrl_rd)));
  // R3
  lock_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !open_q);
endmodule

// File: rtl/smg_tseg.sv
module smg_tseg
  import smg_pkg::*;
#(
  parameter int EXT_MB = 16
) (
  input  logic              t_en,
  input  logic [1:0]        t_code,
  input  logic [ADDR_W-1:0] tolm,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int MB_W = 12;
  logic [MB_W-1:0]   size_mb;
  logic [ADDR_W:0]   size_b;
  logic [ADDR_W:0]   base_w;
  logic [ADDR_W-1:0] base;

  always_comb begin
    size_mb = '0;
    if (t_en) begin
      case (t_code)
        2'd0:    size_mb = MB_W'(1);
        2'd1:    size_mb = MB_W'(2);
        2'd2:    size_mb = MB_W'(8);
        default: size_mb = MB_W'(EXT_MB);
      endcase
    end
    size_b = {(ADDR_W+1-MB_W-20)'(0), size_mb, 20'd0};
    base_w = {1'b0, tolm} - size_b;
    base   = base_w[ADDR_W] ? '0 : base_w[ADDR_W-1:0];
    hit    = (size_mb != '0) && (addr >= base) && (addr < tolm);
  end
endmodule

// File: rtl/smg_route.sv
module smg_route
  import smg_pkg::*;
(
  input  logic              smm,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              g_en,
  input  logic              open_q,
  input  logic              h_en,
  input  logic              tseg_hit,
  output route_e            route,
  output logic [DATA_W-1:0] rdata
);
  logic   in_low, in_high;
  route_e plain;

  assign in_low  = (addr >= LOW_LO)  && (addr <= LOW_HI);
  assign in_high = (addr >= HIGH_LO) && (addr <= HIGH_HI);

  always_comb begin
    plain = RT_PASS;
    route = RT_PASS;
    if (tseg_hit) begin
      route = smm ? RT_DRAM : RT_SINK;
    end else if (in_low) begin
      plain = (open_q && !h_en) ? RT_DRAM : RT_BUS;
      route = (smm && g_en && !h_en) ? RT_DRAM : plain;
    end else if (in_high) begin
      plain = (open_q && h_en) ? RT_DRAM : RT_PASS;
      route = (smm && g_en && h_en) ? RT_DRAM : plain;
    end
    rdata = (route == RT_SINK && !write) ? '1 : '0;
  end
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smg_pkg::*;
#(
  parameter int EXT_MB     = 16,
  parameter int EXT_MB_MAX = 4095
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [7:0]        ctrl_rd,
  output logic [7:0]        ectrl_rd,
  output logic [REG_W-1:0]  xsize_rd,
  input  logic [ADDR_W-1:0] tolm,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_route,
  output logic [DATA_W-1:0] rsp_rdata
);
  generate
    if (EXT_MB > EXT_MB_MAX) begin : g_bad_size
      $error("EXT_MB above EXT_MB_MAX");
    end
  endgenerate

  logic              g_en, open_q, lock_q, t_en, h_en, tseg_hit;
  logic [1:0]        t_code;
  route_e            route_w;
  logic [DATA_W-1:0] rdata_w;

  smg_regs #(.EXT_MB(EXT_MB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .g_en(g_en), .open_q(open_q), .lock_q(lock_q), .t_en(t_en), .t_code(t_code),
    .h_en(h_en), .ctrl_rd(ctrl_rd), .ectrl_rd(ectrl_rd), .xsize_rd(xsize_rd)
  );

  smg_tseg #(.EXT_MB(EXT_MB)) u_tseg (
    .t_en(t_en), .t_code(t_code), .tolm(tolm), .addr(acc_addr), .hit(tseg_hit)
  );

  smg_route u_route (
    .smm(acc_smm), .write(acc_write), .addr(acc_addr), .g_en(g_en),
    .open_q(open_q), .h_en(h_en), .tseg_hit(tseg_hit),
    .route(route_w), .rdata(rdata_w)
  );

  assign acc_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_route <= 2'd0;
      rsp_rdata <= '0;
    end else if (acc_ready) begin
      rsp_valid <= acc_valid;
      if (acc_valid) begin
        rsp_route <= route_w;
        rsp_rdata <= rdata_w;
      end
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_route) && $stable(rsp_rdata)));
  // R8
  rsp_ones_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_rdata != '0) |-> (rsp_route == RT_SINK));
  // R9
  smm_no_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_smm) |-> (route_w != RT_SINK));
  // R7
  tseg_below_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tseg_hit |-> (acc_addr < tolm));
endmodule

// File: tb/smram_guard_tb.sv
`timescale 1ns/1ps
module smram_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [7:0]  ctrl_rd, ectrl_rd;
  logic [15:0] xsize_rd;
  logic [31:0] tolm = 32'h8000_0000;
  logic        acc_valid = 1'b0, acc_smm = 1'b0, acc_write = 1'b0, rsp_ready = 1'b1;
  logic [31:0] acc_addr = 32'd0;
  logic        acc_ready, rsp_valid;
  logic [1:0]  rsp_route;
  logic [31:0] rsp_rdata;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  smram_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .ectrl_rd(ectrl_rd), .xsize_rd(xsize_rd), .tolm(tolm),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_smm(acc_smm), .acc_write(acc_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_route(rsp_route), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  ectrl;
    logic [31:0] top;
    logic        smm;
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  route;
    logic [31:0] rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 32'h000A_0000, 2'd2, 32'h0, 8'd4},         // R4 closed
    '{8'h02, 8'h00, 32'h8000_0000, 1'b0, 1'b0, 32'h000B_0000, 2'd1, 32'h0, 8'd4},         // R4 open
    '{8'h02, 8'h08, 32'h8000_0000, 1'b0, 1'b0, 32'h000A_0000, 2'd2, 32'h0, 8'd4},         // R4 open+high
    '{8'h02, 8'h08, 32'h8000_0000, 1'b0, 1'b0, 32'hFEDA_0000, 2'd1, 32'h0, 8'd5},         // R5
    '{8'h00, 8'h08, 32'h8000_0000, 1'b0, 1'b0, 32'hFEDB_0000, 2'd0, 32'h0, 8'd5},         // R5
    '{8'h01, 8'h00, 32'h8000_0000, 1'b1, 1'b0, 32'h000B_FFFF, 2'd1, 32'h0, 8'd6},         // R6
    '{8'h01, 8'h08, 32'h8000_0000, 1'b1, 1'b0, 32'hFEDB_FFFF, 2'd1, 32'h0, 8'd6},         // R6
    '{8'h01, 8'h08, 32'h8000_0000, 1'b1, 1'b0, 32'h000A_0000, 2'd2, 32'h0, 8'd6},         // R6
    '{8'h00, 8'h08, 32'h8000_0000, 1'b1, 1'b0, 32'hFEDA_0000, 2'd0, 32'h0, 8'd6},         // R6
    '{8'h00, 8'h01, 32'h8000_0000, 1'b0, 1'b0, 32'h7FF0_0000, 2'd3, 32'hFFFF_FFFF, 8'd8}, // R8 1MB
    '{8'h00, 8'h01, 32'h8000_0000, 1'b0, 1'b0, 32'h7FEF_FFFC, 2'd0, 32'h0, 8'd7},         // R7 below
    '{8'h00, 8'h03, 32'h8000_0000, 1'b0, 1'b0, 32'h7FE0_0000, 2'd3, 32'hFFFF_FFFF, 8'd7}, // R7 2MB
    '{8'h00, 8'h05, 32'h8000_0000, 1'b0, 1'b1, 32'h7F80_0000, 2'd3, 32'h0, 8'd8},         // R8 write
    '{8'h00, 8'h07, 32'h8000_0000, 1'b0, 1'b0, 32'h7F00_0000, 2'd3, 32'hFFFF_FFFF, 8'd7}, // R7 ext
    '{8'h00, 8'h07, 32'h8000_0000, 1'b0, 1'b0, 32'h7EFF_FFFF, 2'd0, 32'h0, 8'd7},         // R7 ext edge
    '{8'h00, 8'h07, 32'h8000_0000, 1'b1, 1'b0, 32'h7FFF_FFFC, 2'd1, 32'h0, 8'd9},         // R9
    '{8'h00, 8'h06, 32'h8000_0000, 1'b0, 1'b0, 32'h7FFF_FFFC, 2'd0, 32'h0, 8'd7},         // R7 off
    '{8'h00, 8'h01, 32'h8000_0000, 1'b0, 1'b0, 32'h8000_0000, 2'd0, 32'h0, 8'd7},         // R7 top
    '{8'h03, 8'h08, 32'h8000_0000, 1'b0, 1'b0, 32'h0000_1000, 2'd0, 32'h0, 8'd12},        // R12
    '{8'h00, 8'h05, 32'h4000_0000, 1'b0, 1'b0, 32'h3F80_0000, 2'd3, 32'hFFFF_FFFF, 8'd7}  // R7 other top
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic access(input logic smm, input logic wr, input logic [31:0] a);
    @(negedge clk);
    acc_valid = 1'b1; acc_smm = smm; acc_write = wr; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctrl", 32'(ctrl_rd), 32'h00);
    check("R1 ectrl", 32'(ectrl_rd), 32'h00);
    check("R1 xsize", 32'(xsize_rd), 32'hFFFF);
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after release", 32'(rsp_valid), 32'h0);

    for (int i = 0; i < NV; i++) begin
      wreg(2'd0, {8'h00, VEC[i].ctrl});
      wreg(2'd1, {8'h00, VEC[i].ectrl});
      tolm = VEC[i].top;
      access(VEC[i].smm, VEC[i].wr, VEC[i].addr);
      check($sformatf("R%0d vec%0d valid", VEC[i].req, i), 32'(rsp_valid), 32'h1);
      check($sformatf("R%0d vec%0d route", VEC[i].req, i), 32'(rsp_route), 32'(VEC[i].route));
      check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), rsp_rdata, VEC[i].rdata);
    end
    tolm = 32'h8000_0000;

    // R2 unused bits read zero
    wreg(2'd0, 16'h00FB);
    check("R2 ctrl mask", 32'(ctrl_rd), 32'h03);
    wreg(2'd1, 16'h00FF);
    check("R2 ectrl mask", 32'(ectrl_rd), 32'h0F);

    // R10 size register query
    wreg(2'd2, 16'h1234);
    check("R10 plain store", 32'(xsize_rd), 32'h1234);
    wreg(2'd2, 16'hFFFF);
    check("R10 query load", 32'(xsize_rd), 32'd16);

    // R11 stall holds decision
    wreg(2'd0, 16'h0000);
    wreg(2'd1, 16'h0001);
    @(negedge clk);
    rsp_ready = 1'b0;
    acc_valid = 1'b1; acc_smm = 1'b0; acc_write = 1'b0; acc_addr = 32'h7FF0_0000;
    @(negedge clk);
    acc_addr = 32'h0000_1000;
    check("R11 ready low", 32'(acc_ready), 32'h0);
    @(negedge clk);
    @(negedge clk);
    check("R11 held valid", 32'(rsp_valid), 32'h1);
    check("R11 held route", 32'(rsp_route), 32'd3);
    check("R11 held data", rsp_rdata, 32'hFFFF_FFFF);
    rsp_ready = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R11 next route", 32'(rsp_route), 32'd0);
    check("R11 next data", rsp_rdata, 32'h0);

    // R3 lock closes open and freezes
    wreg(2'd0, 16'h0003);
    wreg(2'd1, 16'h0000);
    wreg(2'd0, 16'h0007);
    check("R3 lock sets, open cleared", 32'(ctrl_rd), 32'h05);
    wreg(2'd0, 16'h0002);
    check("R3 ctrl frozen", 32'(ctrl_rd), 32'h05);
    wreg(2'd1, 16'h0009);
    check("R3 ectrl frozen", 32'(ectrl_rd), 32'h00);
    access(1'b0, 1'b0, 32'h000A_0000);
    check("R3 closed low window to bus", 32'(rsp_route), 32'd2);
    wreg(2'd2, 16'h0042);
    check("R10 size writable under lock", 32'(xsize_rd), 32'h0042);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 reset clears lock", 32'(ctrl_rd), 32'h00);
    wreg(2'd0, 16'h0002);
    check("R3 writable after reset", 32'(ctrl_rd), 32'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule